// File: doc/BRIEF.md
# Level-Sensitive Interrupt Pending Tracker

This block holds the Pending and Active flags for a bank of external interrupt lines. It samples each line once per clock, keeps the previous sample and turns a low-to-high step into a pending request. While a line is held high and its interrupt is not being serviced, the request cannot be withdrawn by software. The core signals an acknowledge when it starts servicing an interrupt and a completion when it finishes. Each of these strobes carries an interrupt number.

Software reaches the block through a write port that carries a set-or-clear kind, a byte offset, a data word and a secure attribute. Bit i of the data word selects interrupt 8 × offset + i. Each selected bit is honoured only if the access is secure or the interrupt is routed to the non-secure side. The block does no arbitration, enabling or vectoring. It reports the pending and active vectors and the sampled line levels to logic that does.

Top module: `irq_pend_tracker`

## Requirements
- R1: A line sampled high when its previous sample was low sets Pending for that interrupt at the next edge, whether or not the interrupt is Active.
- R2: A completion for an Active interrupt clears Active. If the line is high in that cycle, Pending is also set. A completion for an interrupt that is not Active changes nothing.
- R3: A permitted clear write (kind 1) clears Pending, except when the line is sampled high and the interrupt is not Active. In that case the bit stays set.
- R4: An acknowledge clears Pending and sets Active at the next edge, even when the line is high. Active is never set by anything else.
- R5: A line going from high to low leaves Pending unchanged.
- R6: Write data bit i maps to interrupt 8 × offset + i. Bits mapping at or above NUM_IRQ are dropped. Acknowledge and completion numbers at or above NUM_IRQ have no effect.
- R7: A selected write bit takes effect only when the access is secure or the interrupt's non-secure target bit is 1.
- R8: A permitted set write (kind 0) sets Pending regardless of the line level.
- R9: A rising edge in the same cycle as a permitted clear or an acknowledge of the same interrupt leaves Pending at 1.
- R10: A synchronous active-high reset clears Pending, Active and the level samples. After reset, the level output shows the line levels sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_level_i | input | NUM_IRQ | Raw interrupt line levels, already synchronous to clk |
| ns_target_i | input | NUM_IRQ | Per-interrupt non-secure routing bits |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | ID_W | Interrupt number being acknowledged |
| cpl_valid_i | input | 1 | Completion strobe |
| cpl_id_i | input | ID_W | Interrupt number being completed |
| wr_valid_i | input | 1 | Register write strobe |
| wr_kind_i | input | 1 | 0 = set pending, 1 = clear pending |
| wr_secure_i | input | 1 | Secure attribute of the write |
| wr_byte_ofs_i | input | OFS_W | Byte offset of the write within the register space |
| wr_data_i | input | WR_W | Bitmask of interrupts to set or clear |
| pending_o | output | NUM_IRQ | Pending flags |
| active_o | output | NUM_IRQ | Active flags |
| level_o | output | NUM_IRQ | Line levels sampled at the previous edge |

## Verification
The properties assume the lines are already synchronous to the clock and stable over each cycle. They also assume that an acknowledge and a completion naming the same interrupt in one cycle resolve with the acknowledge winning. The stimulus changes lines and strobes only at the falling edge and holds each strobe for exactly one cycle. It includes deliberate same-cycle collisions of an edge with a clear and of an edge with an acknowledge, so the precedence rules are exercised rather than avoided.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    localparam int BITS_PER_BYTE = 8;

    typedef enum logic {
        WR_SET   = 1'b0,
        WR_CLEAR = 1'b1
    } wr_kind_e;

    typedef struct packed {
        logic pend;
        logic act;
    } irq_state_t;

    // Pending must not be dropped while the line holds the request and
    // nobody is servicing it.
    function automatic logic clear_blocked(input logic level, input logic active);
        return level & ~active;
    endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int N = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] prev_o,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= lvl_i;
        end
    end

    assign prev_o = prev_q;
    assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/irq_strobe_dec.sv
module irq_strobe_dec #(
    parameter int N    = 28,
    parameter int ID_W = 5
) (
    input  logic            valid_i,
    input  logic [ID_W-1:0] id_i,
    output logic [N-1:0]    hit_o
);

    for (genvar n = 0; n < N; n++) begin : g_dec
        // numbers at or above N match no slot and are dropped
        assign hit_o[n] = valid_i && (id_i == ID_W'(n));
    end

endmodule

// File: rtl/irq_wr_dec.sv
module irq_wr_dec
    import irq_pend_pkg::*;
#(
    parameter int N     = 28,
    parameter int WR_W  = 32,
    parameter int OFS_W = 3
) (
    input  logic             valid_i,
    input  logic             kind_i,
    input  logic             secure_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [WR_W-1:0]  data_i,
    input  logic [N-1:0]     ns_target_i,
    output logic [N-1:0]     set_ok_o,
    output logic [N-1:0]     clr_ok_o
);

    localparam int SPAN = N + WR_W;

    wr_kind_e     kind;
    logic [SPAN-1:0] window;
    logic [N-1:0] permit;
    logic [N-1:0] sel;

    assign kind   = wr_kind_e'(kind_i);
    // bits landing at or above N fall off the top of the used slice
    assign window = SPAN'(data_i) << (BITS_PER_BYTE * int'(ofs_i));
    assign permit = {N{secure_i}} | ns_target_i;
    assign sel    = valid_i ? (window[N-1:0] & permit) : '0;

    always_comb begin
        set_ok_o = '0;
        clr_ok_o = '0;
        unique case (kind)
            WR_SET:   set_ok_o = sel;
            WR_CLEAR: clr_ok_o = sel;
        endcase
    end

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
    import irq_pend_pkg::*;
#(
    parameter int N = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] ack_i,
    input  logic [N-1:0] cpl_i,
    input  logic [N-1:0] set_ok_i,
    input  logic [N-1:0] clr_ok_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] act_o
);

    for (genvar n = 0; n < N; n++) begin : g_irq
        irq_state_t st_q;
        irq_state_t st_d;
        logic       clr_eff;
        logic       repend;

        always_comb begin
            clr_eff = clr_ok_i[n] & ~clear_blocked(lvl_i[n], st_q.act);
            repend  = cpl_i[n] & st_q.act & lvl_i[n] & ~ack_i[n];
            st_d.pend = (st_q.pend & ~ack_i[n] & ~clr_eff)
                      | rise_i[n] | set_ok_i[n] | repend;
            st_d.act  = ack_i[n] | (st_q.act & ~cpl_i[n]);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign pend_o[n] = st_q.pend;
        assign act_o[n]  = st_q.act;
    end

endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker #(
    parameter int NUM_IRQ = 28,
    parameter int WR_W    = 32,
    parameter int OFS_W   = 3,
    localparam int ID_W   = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_level_i,
    input  logic [NUM_IRQ-1:0] ns_target_i,
    input  logic               ack_valid_i,
    input  logic [ID_W-1:0]    ack_id_i,
    input  logic               cpl_valid_i,
    input  logic [ID_W-1:0]    cpl_id_i,
    input  logic               wr_valid_i,
    input  logic               wr_kind_i,
    input  logic               wr_secure_i,
    input  logic [OFS_W-1:0]   wr_byte_ofs_i,
    input  logic [WR_W-1:0]    wr_data_i,
    output logic [NUM_IRQ-1:0] pending_o,
    output logic [NUM_IRQ-1:0] active_o,
    output logic [NUM_IRQ-1:0] level_o
);

    logic [NUM_IRQ-1:0] rise;
    logic [NUM_IRQ-1:0] ack_hit;
    logic [NUM_IRQ-1:0] cpl_hit;
    logic [NUM_IRQ-1:0] set_ok;
    logic [NUM_IRQ-1:0] clr_ok;

    irq_edge_det #(.N(NUM_IRQ)) edge_i (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (irq_level_i),
        .prev_o (level_o),
        .rise_o (rise)
    );

    irq_strobe_dec #(.N(NUM_IRQ), .ID_W(ID_W)) ack_dec_i (
        .valid_i (ack_valid_i),
        .id_i    (ack_id_i),
        .hit_o   (ack_hit)
    );

    irq_strobe_dec #(.N(NUM_IRQ), .ID_W(ID_W)) cpl_dec_i (
        .valid_i (cpl_valid_i),
        .id_i    (cpl_id_i),
        .hit_o   (cpl_hit)
    );

    irq_wr_dec #(.N(NUM_IRQ), .WR_W(WR_W), .OFS_W(OFS_W)) wr_dec_i (
        .valid_i     (wr_valid_i),
        .kind_i      (wr_kind_i),
        .secure_i    (wr_secure_i),
        .ofs_i       (wr_byte_ofs_i),
        .data_i      (wr_data_i),
        .ns_target_i (ns_target_i),
        .set_ok_o    (set_ok),
        .clr_ok_o    (clr_ok)
    );

    irq_state_bank #(.N(NUM_IRQ)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .lvl_i    (irq_level_i),
        .rise_i   (rise),
        .ack_i    (ack_hit),
        .cpl_i    (cpl_hit),
        .set_ok_i (set_ok),
        .clr_ok_i (clr_ok),
        .pend_o   (pending_o),
        .act_o    (active_o)
    );

endmodule

// File: rtl/irq_pend_tracker_chk.sv
module irq_pend_tracker_chk #(
    parameter int NUM_IRQ = 28,
    parameter int ID_W    = 5
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_IRQ-1:0] irq_level_i,
    input logic               ack_valid_i,
    input logic [ID_W-1:0]    ack_id_i,
    input logic               cpl_valid_i,
    input logic [ID_W-1:0]    cpl_id_i,
    input logic               wr_valid_i,
    input logic [NUM_IRQ-1:0] pending_o,
    input logic [NUM_IRQ-1:0] active_o,
    input logic [NUM_IRQ-1:0] level_o
);

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (pending_o == '0 && active_o == '0 && level_o == '0));

    // R1
    rise_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_level_i & ~level_o) != '0) |=>
        ((pending_o & $past(irq_level_i & ~level_o)) == $past(irq_level_i & ~level_o)));

    // R4
    ack_sets_active_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid_i && (int'(ack_id_i) < NUM_IRQ)) |=> active_o[$past(ack_id_i)]);

    // R4
    active_only_by_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_valid_i |=> (($past(~active_o) & active_o) == '0));

    // R2
    cpl_repend_chk: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid_i && (int'(cpl_id_i) < NUM_IRQ) && active_o[cpl_id_i]
         && irq_level_i[cpl_id_i] && !(ack_valid_i && ack_id_i == cpl_id_i))
        |=> (pending_o[$past(cpl_id_i)] && !active_o[$past(cpl_id_i)]));

    // R3
    held_line_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_valid_i |=>
        ((pending_o & $past(irq_level_i & ~active_o & pending_o))
          == $past(irq_level_i & ~active_o & pending_o)));

    // R5
    no_silent_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_valid_i && !wr_valid_i) |=> (($past(pending_o) & ~pending_o) == '0));

endmodule

bind irq_pend_tracker irq_pend_tracker_chk #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) chk_i (.*);

// File: tb/irq_pend_tracker_tb_top.sv
`timescale 1ns/1ps
module irq_pend_tracker_tb_top;

    localparam int NUM_IRQ = 28;
    localparam int WR_W    = 32;
    localparam int OFS_W   = 3;
    localparam int ID_W    = $clog2(NUM_IRQ);

    typedef struct {
        logic [NUM_IRQ-1:0] pend;
        logic [NUM_IRQ-1:0] act;
        logic [NUM_IRQ-1:0] lvl;
        string              tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM_IRQ-1:0] lvl = '0;
    logic [NUM_IRQ-1:0] ns  = '0;
    logic               ack_v = 1'b0;
    logic [ID_W-1:0]    ack_id = '0;
    logic               cpl_v = 1'b0;
    logic [ID_W-1:0]    cpl_id = '0;
    logic               wr_v = 1'b0;
    logic               wr_clr = 1'b0;
    logic               wr_sec = 1'b1;
    logic [OFS_W-1:0]   wr_ofs = '0;
    logic [WR_W-1:0]    wr_dat = '0;
    logic [NUM_IRQ-1:0] pending, active, level;

    logic [NUM_IRQ-1:0] m_pend = '0, m_act = '0, m_prev = '0;
    exp_t q[$];
    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_pend_tracker #(.NUM_IRQ(NUM_IRQ), .WR_W(WR_W), .OFS_W(OFS_W)) dut_i (
        .clk (clk), .rst (rst),
        .irq_level_i (lvl), .ns_target_i (ns),
        .ack_valid_i (ack_v), .ack_id_i (ack_id),
        .cpl_valid_i (cpl_v), .cpl_id_i (cpl_id),
        .wr_valid_i (wr_v), .wr_kind_i (wr_clr), .wr_secure_i (wr_sec),
        .wr_byte_ofs_i (wr_ofs), .wr_data_i (wr_dat),
        .pending_o (pending), .active_o (active), .level_o (level)
    );

    // Reference state derived from the requirements; clears first, then sets.
    task automatic model_step();
        logic [NUM_IRQ-1:0] np, na;
        np = m_pend; na = m_act;
        if (rst) begin
            np = '0; na = '0;
        end else begin
            for (int n = 0; n < NUM_IRQ; n++) begin
                int  idx;
                bit  sel;
                idx = n - 8 * int'(wr_ofs);
                sel = wr_v && idx >= 0 && idx < WR_W && wr_dat[idx] && (wr_sec || ns[n]);
                if (sel && wr_clr && !(lvl[n] && !m_act[n])) np[n] = 1'b0;     // R3
                if (ack_v && int'(ack_id) == n) begin                          // R4
                    np[n] = 1'b0; na[n] = 1'b1;
                end else if (cpl_v && int'(cpl_id) == n && m_act[n]) begin     // R2
                    na[n] = 1'b0;
                    if (lvl[n]) np[n] = 1'b1;
                end
                if (sel && !wr_clr) np[n] = 1'b1;                              // R8
                if (lvl[n] && !m_prev[n]) np[n] = 1'b1;                        // R1, R9
            end
        end
        m_pend = np;
        m_act  = na;
        m_prev = rst ? '0 : lvl;
    endtask

    task automatic cyc(input string tag);
        exp_t e;
        model_step();
        e.pend = m_pend; e.act = m_act; e.lvl = m_prev; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        ack_v = 1'b0; cpl_v = 1'b0; wr_v = 1'b0;
    endtask

    task automatic wr(input bit clr, input bit sec, input int ofs, input logic [WR_W-1:0] d);
        wr_v = 1'b1; wr_clr = clr; wr_sec = sec; wr_ofs = OFS_W'(ofs); wr_dat = d;
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (pending !== e.pend || active !== e.act || level !== e.lvl) begin
                n_bad++;
                $display("FAIL %s: pend=%h act=%h lvl=%h expected pend=%h act=%h lvl=%h",
                         e.tag, pending, active, level, e.pend, e.act, e.lvl);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        lvl = 28'h00f0f0f;
        cyc("R10 reset");
        lvl = '0;
        cyc("R10 reset");
        rst = 1'b0;
        cyc("R10 idle");

        lvl[3] = 1'b1;            cyc("R1 rise sets");
        lvl[3] = 1'b0;            cyc("R5 fall keeps");
        wr(1, 1, 0, 32'h8);       cyc("R3 clear low line");

        lvl[5] = 1'b1;            cyc("R1 rise irq5");
        wr(1, 1, 0, 32'h20);      cyc("R3 clear blocked");
        ack_v = 1; ack_id = 5;    cyc("R4 ack with line high");
        lvl[5] = 1'b0;            cyc("R5 fall while active");
        lvl[5] = 1'b1;            cyc("R1 rise while active");
        wr(1, 1, 0, 32'h20);      cyc("R3 clear allowed while active");
        cpl_v = 1; cpl_id = 5;    cyc("R2 complete repends");
        lvl[5] = 1'b0;            cyc("R5 fall");
        wr(1, 1, 0, 32'h20);      cyc("R3 clear after fall");
        ack_v = 1; ack_id = 5;    cyc("R4 ack not pending");
        cpl_v = 1; cpl_id = 5;    cyc("R2 complete line low");

        lvl[7] = 1'b1;            cyc("R1 rise irq7");
        ack_v = 1; ack_id = 7;    cyc("R4 ack irq7");
        wr(1, 1, 0, 32'h80);      cyc("R3 clear irq7 not pending");
        cpl_v = 1; cpl_id = 9;    cyc("R2 complete inactive irq");
        cpl_v = 1; cpl_id = 7;    cyc("R2 complete irq7 repends");

        wr(0, 1, 1, 32'h0000_0005); cyc("R8 R6 set offset 1");
        lvl[20] = 1'b1;           cyc("R1 rise irq20");
        wr(0, 1, 2, 32'h0000_0010); cyc("R8 set with line high");

        ns = 28'h0000_a00;
        wr(0, 0, 1, 32'h0000_000f); cyc("R7 nonsecure set");
        wr(1, 0, 1, 32'h0000_000f); cyc("R7 nonsecure clear");
        wr(1, 1, 1, 32'h0000_00ff); cyc("R7 secure clear");

        wr(0, 1, 3, 32'hffff_ffff); cyc("R6 set beyond NUM_IRQ");
        wr(1, 1, 3, 32'hffff_ffff); cyc("R6 clear top byte");
        wr(0, 1, 4, 32'hffff_ffff); cyc("R6 set fully out of range");
        ack_v = 1; ack_id = 5'd30; cyc("R6 ack out of range");
        cpl_v = 1; cpl_id = 5'd29; cyc("R6 complete out of range");

        lvl[12] = 1'b1; wr(1, 1, 1, 32'h10); cyc("R9 rise with clear");
        lvl[13] = 1'b1; ack_v = 1; ack_id = 13; cyc("R9 rise with ack");
        cpl_v = 1; cpl_id = 13;   cyc("R2 complete irq13");

        lvl = '0; rst = 1'b1;     cyc("R10 reset again");
        rst = 1'b0;               cyc("R10 after reset");

        @(posedge clk); #2;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule